// File: doc/BRIEF.md
# SEC-DED Protected Memory Front End

This block sits between a single requester and a synchronous memory that stores data and check bits side by side. Each 16-bit user word is split into four nibbles. Every nibble is encoded on its own into an 8-bit single-error-correcting, double-error-detecting codeword, and the four codewords are stored together as one 32-bit memory word. On a read the stored word is decoded lane by lane. The corrected data is returned with a one-cycle acknowledge pulse, and a flag shows whether any lane was found corrupted.

Any word that decodes with only correctable lanes is repaired in memory. A user read writes the repaired word back in the same cycle that the memory returns it. When no request is present, the block walks the address space one word per cycle, reading each word and repairing it in place. User requests always win the port. The only time a user request waits is the one cycle in which a repair write from the idle walk is in progress. A word with a double error in any lane is reported but never rewritten. The memory answers a read one cycle after it is issued, and the handshake hides that latency from the requester.

Top module: `ecc_prot_unit`

## Requirements
- R1: Each nibble d[3:0] is stored as codeword c[7:0] with c0=d0^d1^d3, c1=d0^d2^d3, c2=d0, c3=d1^d2^d3, c4=d1, c5=d2, c6=d3 and c7 the XOR of c0..c6. Nibble n of the user word occupies memory bits [8n+7:8n].
- R2: A write is taken when req and wr are high. The encoded word is written to memory at addr, and ack pulses one cycle after the cycle in which the write was taken.
- R3: ack is high for exactly one cycle per request. For a read it rises two cycles after the cycle in which the read was taken, which is one cycle after the memory returns data. A request is never taken in a cycle where ack is high.
- R4: Reading an uncorrupted word returns the stored 16-bit data with err low.
- R5: A single flipped bit in any lane, including the lane's overall parity bit c7, is corrected in rdata and raises err. Several lanes may each hold one flipped bit. The repaired word is written back to the same address before ack is seen.
- R6: When any lane holds two flipped bits, err is raised and the word is never written back, whether it was reached by a read or by the idle walk. For such a lane, rdata carries the stored bits c6,c5,c4,c2 unchanged.
- R7: While req is high, every memory read that is issued targets addr. The idle walk starts no read while req is high.
- R8: With req low, the block reads one word per cycle at consecutive addresses, wrapping from the top address to 0, and repairs every word whose lanes are all correctable.
- R9: A repair found by the idle walk is written in the cycle after the walk's read. A request presented in that cycle is delayed by one cycle. The exception is a user write to the same address: that write is taken in place of the repair, and the repair is dropped.
- R10: While reset is asserted, and until the internal release completes, ack, err and mem_en are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request, held until ack |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | AW | Word address |
| wdata | input | DW | Write data |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | DW | Corrected read data, valid with ack |
| err | output | 1 | Corruption seen on the acknowledged read |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | 2*DW | Encoded word to memory |
| mem_rdata | input | 2*DW | Stored word, one cycle after a read |

## Verification
The bench builds the block with AW=3 and the default DW=16. With only eight words, the idle walk wraps every eight idle cycles. The bench can therefore catch the walk reading a chosen corrupted address within a few cycles and place a request exactly in the repair cycle, which exercises both the delayed request and the dropped repair. Single-bit faults are injected at all 32 stored bit positions, so every lane and every check bit passes through the corrector.

// File: rtl/ecc_pu_pkg.sv
package ecc_pu_pkg;
  localparam int NIB_W  = 4;
  localparam int CODE_W = 8;

  typedef logic [CODE_W-1:0] code_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_URD  = 2'd1,
    ST_SRD  = 2'd2
  } pu_state_e;
endpackage

// File: rtl/ecc_rst_sync.sv
module ecc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_ns = sync_q[1];
endmodule

// File: rtl/ecc_nib_enc.sv
module ecc_nib_enc
  import ecc_pu_pkg::*;
(
  input  logic [NIB_W-1:0] data_i,
  output code_t            code_o
);
  logic [6:0] body;

  always_comb begin
    body[0] = data_i[0] ^ data_i[1] ^ data_i[3];
    body[1] = data_i[0] ^ data_i[2] ^ data_i[3];
    body[2] = data_i[0];
    body[3] = data_i[1] ^ data_i[2] ^ data_i[3];
    body[4] = data_i[1];
    body[5] = data_i[2];
    body[6] = data_i[3];
  end

  assign code_o = {^body, body};
endmodule

// File: rtl/ecc_nib_dec.sv
module ecc_nib_dec
  import ecc_pu_pkg::*;
(
  input  code_t            code_i,
  output logic [NIB_W-1:0] data_o,
  output code_t            code_o,
  output logic             sgl_o,
  output logic             dbl_o
);
  logic [2:0] syn;
  logic       par;
  code_t      mask;

  always_comb begin
    syn[0] = code_i[0] ^ code_i[2] ^ code_i[4] ^ code_i[6];
    syn[1] = code_i[1] ^ code_i[2] ^ code_i[5] ^ code_i[6];
    syn[2] = code_i[3] ^ code_i[4] ^ code_i[5] ^ code_i[6];
    par    = ^code_i;
    mask   = '0;
    if (par) begin
      if (syn == 3'd0) mask[7] = 1'b1;
      else begin
        for (int i = 1; i < 8; i++) begin
          if (syn == 3'(i)) mask[i-1] = 1'b1;
        end
      end
    end
  end

  assign code_o = code_i ^ mask;
  assign data_o = {code_o[6], code_o[5], code_o[4], code_o[2]};
  assign sgl_o  = par;
  assign dbl_o  = !par && (syn != 3'd0);
endmodule

// File: rtl/ecc_scrub_ptr.sv
module ecc_scrub_ptr #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_ns,
  input  logic          step_i,
  output logic [AW-1:0] ptr_o
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (step_i) ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) ptr_q <= '0;
    else         ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/ecc_prot_unit.sv
module ecc_prot_unit
  import ecc_pu_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req,
  input  logic            wr,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic            ack,
  output logic [DW-1:0]   rdata,
  output logic            err,
  output logic            mem_en,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [2*DW-1:0] mem_wdata,
  input  logic [2*DW-1:0] mem_rdata
);
  localparam int NL = DW / NIB_W;
  localparam int MW = NL * CODE_W;

  logic            rst_ns;
  logic            live_q;
  pu_state_e       state_q, state_d;
  logic [AW-1:0]   rd_addr_q, rd_addr_d;
  logic            rd_addr_en;
  logic            ack_q, ack_d;
  logic [DW-1:0]   rdata_q, rdata_d;
  logic            rdata_en;
  logic            err_q, err_d;
  logic [AW-1:0]   scrub_addr;
  logic [MW-1:0]   enc_word, fixed_word;
  logic [DW-1:0]   dec_data;
  logic [NL-1:0]   lane_sgl, lane_dbl;
  logic            any_sgl, any_dbl, fixable;
  logic            user_ok, do_user, do_wb, do_scrub;

  ecc_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_ns(rst_ns));

  for (genvar g = 0; g < NL; g++) begin : g_lane
    ecc_nib_enc u_enc (
      .data_i(wdata[NIB_W*g +: NIB_W]),
      .code_o(enc_word[CODE_W*g +: CODE_W])
    );
    ecc_nib_dec u_dec (
      .code_i(mem_rdata[CODE_W*g +: CODE_W]),
      .data_o(dec_data[NIB_W*g +: NIB_W]),
      .code_o(fixed_word[CODE_W*g +: CODE_W]),
      .sgl_o (lane_sgl[g]),
      .dbl_o (lane_dbl[g])
    );
  end

  assign any_sgl = |lane_sgl;
  assign any_dbl = |lane_dbl;
  assign fixable = any_sgl && !any_dbl;

  ecc_scrub_ptr #(.AW(AW)) u_ptr (
    .clk   (clk),
    .rst_ns(rst_ns),
    .step_i(do_scrub),
    .ptr_o (scrub_addr)
  );

  assign user_ok = live_q && req && !ack_q;

  // Port arbitration: user, repair write, or idle walk read.
  always_comb begin
    do_user  = 1'b0;
    do_wb    = 1'b0;
    do_scrub = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (user_ok)              do_user  = 1'b1;
        else if (live_q && !req)  do_scrub = 1'b1;
      end
      ST_URD: begin
        do_wb = fixable;
      end
      ST_SRD: begin
        if (fixable) begin
          if (user_ok && wr && (addr == rd_addr_q)) do_user = 1'b1;
          else                                      do_wb   = 1'b1;
        end else if (user_ok)     do_user  = 1'b1;
        else if (live_q && !req)  do_scrub = 1'b1;
      end
      default: ;
    endcase
  end

  // Memory port drive.
  always_comb begin
    mem_en    = do_user || do_wb || do_scrub;
    mem_we    = (do_user && wr) || do_wb;
    mem_addr  = addr;
    if (do_wb)         mem_addr = rd_addr_q;
    else if (do_scrub) mem_addr = scrub_addr;
    mem_wdata = do_wb ? fixed_word : enc_word;
  end

  // Next-state logic.
  always_comb begin
    state_d    = ST_IDLE;
    rd_addr_d  = rd_addr_q;
    rd_addr_en = 1'b0;
    if (do_user && !wr) begin
      state_d    = ST_URD;
      rd_addr_d  = addr;
      rd_addr_en = 1'b1;
    end else if (do_scrub) begin
      state_d    = ST_SRD;
      rd_addr_d  = scrub_addr;
      rd_addr_en = 1'b1;
    end
    ack_d    = (do_user && wr) || (state_q == ST_URD);
    rdata_en = (state_q == ST_URD);
    rdata_d  = dec_data;
    err_d    = (state_q == ST_URD) && (any_sgl || any_dbl);
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      live_q  <= 1'b0;
      state_q <= ST_IDLE;
      ack_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      live_q  <= 1'b1;
      state_q <= state_d;
      ack_q   <= ack_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)         rd_addr_q <= '0;
    else if (rd_addr_en) rd_addr_q <= rd_addr_d;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)       rdata_q <= '0;
    else if (rdata_en) rdata_q <= rdata_d;
  end

  assign ack   = ack_q;
  assign rdata = rdata_q;
  assign err   = err_q;
endmodule

// File: rtl/ecc_prot_unit_chk.sv
module ecc_prot_unit_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req,
  input logic          wr,
  input logic [AW-1:0] addr,
  input logic          ack,
  input logic          mem_en,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr
);
  // R3: acknowledge never lasts two cycles
  p_ack_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  // R3: every acknowledge follows a memory access one or two cycles earlier
  p_ack_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> ($past(mem_en) || $past(mem_en, 2)));

  // R7: with a request present, reads go only to the requested address
  p_user_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req && mem_en && !mem_we) |-> (mem_addr == addr));

  // R5 / R9: a repair write targets the address read in the previous cycle
  p_wb_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we && !(req && wr)) |->
      ($past(mem_en && !mem_we) && (mem_addr == $past(mem_addr))));
endmodule

bind ecc_prot_unit ecc_prot_unit_chk #(.AW(AW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .req     (req),
  .wr      (wr),
  .addr    (addr),
  .ack     (ack),
  .mem_en  (mem_en),
  .mem_we  (mem_we),
  .mem_addr(mem_addr)
);

// File: tb/sim_ecc_prot_unit.sv
module sim_ecc_prot_unit;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 3;
  localparam int DW = 16;
  localparam int NW = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req, wr;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic          ack, err;
  logic [DW-1:0] rdata;
  logic          mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata, mem_rdata;

  logic [31:0]   mem_m [NW];
  logic [15:0]   gold  [NW];
  logic [31:0]   snap;
  int total = 0;
  int bad = 0;
  int r7_bad = 0;

  logic       q_rd  [$];
  logic [15:0] q_d  [$];
  logic       q_e   [$];
  string      q_tag [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ecc_prot_unit #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr), .wdata(wdata),
    .ack(ack), .rdata(rdata), .err(err), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // Memory model: one-cycle read latency
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) mem_m[mem_addr] <= mem_wdata;
      else        mem_rdata <= mem_m[mem_addr];
    end
  end

  function automatic logic [7:0] t_enc(input logic [3:0] d);
    logic [7:0] c;
    c[0] = d[0] ^ d[1] ^ d[3];
    c[1] = d[0] ^ d[2] ^ d[3];
    c[2] = d[0];
    c[3] = d[1] ^ d[2] ^ d[3];
    c[4] = d[1];
    c[5] = d[2];
    c[6] = d[3];
    c[7] = ^c[6:0];
    return c;
  endfunction

  function automatic logic [31:0] t_word(input logic [15:0] d);
    logic [31:0] w;
    for (int n = 0; n < 4; n++) w[8*n +: 8] = t_enc(d[4*n +: 4]);
    return w;
  endfunction

  function automatic logic [15:0] t_raw(input logic [31:0] w);
    logic [15:0] d;
    for (int n = 0; n < 4; n++)
      d[4*n +: 4] = {w[8*n+6], w[8*n+5], w[8*n+4], w[8*n+2]};
    return d;
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got %h exp %h", tag, what, got, exp);
    end
  endtask

  // Monitor: pops expectations as acknowledges appear
  always @(negedge clk) begin
    if (rst_n) begin
      if (req && mem_en && !mem_we && mem_addr != addr) r7_bad++;
      if (ack) begin
        if (q_rd.size() == 0) chk("R3", "ack without request", 32'd1, 32'd0);
        else begin
          logic is_rd;
          logic [15:0] ed;
          logic ee;
          string tg;
          is_rd = q_rd.pop_front();
          ed = q_d.pop_front();
          ee = q_e.pop_front();
          tg = q_tag.pop_front();
          if (is_rd) begin
            chk(tg, "rdata", 32'(rdata), 32'(ed));
            chk(tg, "err", 32'(err), 32'(ee));
          end
        end
      end
    end
  end

  // Driver: called at a falling edge
  task automatic do_req(input logic w, input int a, input logic [15:0] d,
                        input logic [15:0] exp_d, input logic exp_e,
                        input int exp_lat, input string tag);
    int lat = 0;
    q_rd.push_back(!w); q_d.push_back(exp_d); q_e.push_back(exp_e); q_tag.push_back(tag);
    req = 1'b1; wr = w; addr = AW'(a); wdata = d;
    do begin
      @(negedge clk);
      lat++;
    end while (!ack && lat < 20);
    snap = mem_m[a];
    chk(tag, "ack latency", 32'(lat), 32'(exp_lat));
    req = 1'b0; wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_scrub(input int a);
    int k = 0;
    while (!(mem_en && !mem_we && mem_addr == AW'(a)) && k < 100) begin
      @(negedge clk);
      k++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] pats [8];
    pats[0] = 16'h0000; pats[1] = 16'hFFFF; pats[2] = 16'hA5C3; pats[3] = 16'h1234;
    pats[4] = 16'h8001; pats[5] = 16'h7FFE; pats[6] = 16'h5A5A; pats[7] = 16'hC0DE;
    for (int i = 0; i < NW; i++) begin mem_m[i] = '0; gold[i] = '0; end
    rst_n = 1'b0; req = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
    repeat (4) @(negedge clk);
    // R10: reset state
    chk("R10", "ack", 32'(ack), 32'd0);
    chk("R10", "err", 32'(err), 32'd0);
    chk("R10", "mem_en", 32'(mem_en), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "mem_en after release", 32'(mem_en), 32'd0);
    repeat (3) @(negedge clk);

    // R1 R2: writes store the encoded word
    for (int i = 0; i < NW; i++) begin
      do_req(1'b1, i, pats[i], 16'h0, 1'b0, 1, "R2");
      gold[i] = pats[i];
      chk("R1", "stored word", snap, t_word(pats[i]));
    end

    // R4 R3: clean reads
    for (int i = NW - 1; i >= 0; i--) do_req(1'b0, i, 16'h0, gold[i], 1'b0, 2, "R4");

    // R5: single flip at every stored bit position
    for (int b = 0; b < 32; b++) begin
      int a = b % NW;
      mem_m[a][b] <= ~mem_m[a][b];
      do_req(1'b0, a, 16'h0, gold[a], 1'b1, 2, "R5");
      chk("R5", "write-back", snap, t_word(gold[a]));
    end

    // R5: one flip in each of two lanes
    mem_m[4][3] <= ~mem_m[4][3];
    mem_m[4][20] <= ~mem_m[4][20];
    do_req(1'b0, 4, 16'h0, gold[4], 1'b1, 2, "R5");
    chk("R5", "two-lane write-back", snap, t_word(gold[4]));

    // R6: double flip in lane 0 of word 3
    begin
      logic [31:0] bad_w;
      bad_w = t_word(gold[3]) ^ 32'h0000_0014;
      mem_m[3] <= bad_w;
      do_req(1'b0, 3, 16'h0, t_raw(bad_w), 1'b1, 2, "R6");
      chk("R6", "no write-back on read", snap, bad_w);
      repeat (40) @(negedge clk);
      chk("R6", "walk leaves word", mem_m[3], bad_w);
      do_req(1'b1, 3, gold[3], 16'h0, 1'b0, 1, "R6");
    end

    // R8: idle walk repairs without user access
    mem_m[5][9] <= ~mem_m[5][9];
    mem_m[0][30] <= ~mem_m[0][30];
    repeat (40) @(negedge clk);
    chk("R8", "walk repair a5", mem_m[5], t_word(gold[5]));
    chk("R8", "walk repair a0", mem_m[0], t_word(gold[0]));

    // R8: walk order and wrap
    begin
      int prev = -1;
      for (int k = 0; k < 20; k++) begin
        if (mem_en && !mem_we) begin
          if (prev >= 0) chk("R8", "walk order", 32'(mem_addr), 32'((prev + 1) % NW));
          prev = int'(mem_addr);
        end
        @(negedge clk);
      end
    end

    // R9: request during walk repair is delayed a cycle
    mem_m[2][17] <= ~mem_m[2][17];
    @(negedge clk);
    wait_scrub(2);
    @(negedge clk);
    chk("R9", "repair cycle", {mem_en, mem_we, 27'd0, mem_addr}, {1'b1, 1'b1, 27'd0, 3'd2});
    do_req(1'b0, 6, 16'h0, gold[6], 1'b0, 3, "R9");
    chk("R9", "repaired", mem_m[2], t_word(gold[2]));

    // R9: same-address user write replaces the repair
    mem_m[2][0] <= ~mem_m[2][0];
    @(negedge clk);
    wait_scrub(2);
    @(negedge clk);
    do_req(1'b1, 2, 16'h3C96, 16'h0, 1'b0, 1, "R9");
    gold[2] = 16'h3C96;
    chk("R9", "user data kept", snap, t_word(16'h3C96));
    repeat (20) @(negedge clk);
    chk("R9", "user data after walk", mem_m[2], t_word(16'h3C96));
    do_req(1'b0, 2, 16'h0, 16'h3C96, 1'b0, 2, "R9");

    // R7: no foreign read while a request was up
    chk("R7", "reads off-address under req", 32'(r7_bad), 32'd0);
    chk("R3", "pending expectations", 32'(q_rd.size()), 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule